// File: doc/BRIEF.md
# Snooping Write-Through Coherent Cache

This block is a small direct-mapped data cache for one core in a multicore system. Every store goes to main memory as well as to the cache (write-through). Each cache watches a shared intercore message bus so that no copy it holds goes stale. A core request is held stable until the cache raises ready. Read hits finish in the cycle they are presented. Read misses and all writes each take one memory transaction.

Each cache also broadcasts one message per transaction on the intercore bus. Peers use these messages to drop or refresh their own copies. A parameter selects one of two policies. Under the invalidate policy, a write kills matching copies in peer caches. Under the update policy, the written value is pushed into those copies. Under the invalidate policy, each line also carries a "sole copy" mark. It lets a run of writes to the same line send only one invalidation. The mark is dropped as soon as a peer fetches the line again.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset every line is invalid. `mem_req`, `bus_valid_o` and `req_ready` stay low while no request is presented.
- R2: A read that misses keeps `req_ready` low until the cycle `mem_ack` is high. In that cycle it returns `mem_rdata`, writes the tag, sets the line valid and sends a refill message (kind 3) on the bus.
- R3: A read that hits raises `req_ready` in the same cycle the request is presented, returns the cached value and issues no memory request.
- R4: Every write drives a memory write of its address and data, and completes in the cycle `mem_ack` is high. A write that misses does not allocate a line.
- R5: Under the invalidate policy, a write that needs a message drives `bus_valid_o` for one cycle. It carries kind 1, the written address and this cache's ID in `bus_src_o`.
- R6: A peer invalidation (kind 1) whose address matches a valid line clears that line. The next local read of it misses and returns the new value from memory.
- R7: Under the invalidate policy, once a write hit has sent an invalidation, further write hits to that line send no bus message. Memory is still written.
- R8: A peer refill message (kind 3) for a held line clears its sole-copy mark. The next local write to that line sends an invalidation again.
- R9: Under the update policy, every write sends kind 2 with the written data. Peers holding the line overwrite their copy and keep it valid, so their next read hits with the new value.
- R10: A cache ignores bus messages that carry its own ID. After its own write, its line stays valid and holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | DATA_W | Read data, valid with ready on a read |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transaction completes this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with ack |
| bus_valid_o | output | 1 | Outgoing coherence message valid |
| bus_kind_o | output | 2 | Message kind: 1 invalidate, 2 update, 3 refill |
| bus_addr_o | output | ADDR_W | Message address |
| bus_data_o | output | DATA_W | Message data (written value for updates) |
| bus_src_o | output | ID_W | ID of this cache |
| bus_valid_i | input | 1 | Snooped message valid |
| bus_kind_i | input | 2 | Snooped message kind |
| bus_addr_i | input | ADDR_W | Snooped message address |
| bus_data_i | input | DATA_W | Snooped message data |
| bus_src_i | input | ID_W | Snooped message source ID |

## Verification
The assertions take for granted that the intercore bus carries at most one message per cycle. They also assume that a peer message never arrives in the same cycle as a local refill of the same index. Under that assumption the refill and invalidation properties can check the valid state one cycle later. They further assume the core holds its request fields stable until ready. The stimulus keeps to all of this: cores run one transaction at a time within each bus group, and each request is dropped just after the edge that completes it.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    MSG_NONE = 2'd0,
    MSG_INV  = 2'd1,
    MSG_UPD  = 2'd2,
    MSG_FILL = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WRT  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/swc_line_store.sv
module swc_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup for the core request
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_valid,
  output logic              lk_sole,
  // lookup for the snooped message
  input  logic [IDX_W-1:0]  sn_idx,
  output logic [TAG_W-1:0]  sn_tag,
  output logic              sn_valid,
  // snoop actions
  input  logic              sn_kill,
  input  logic              sn_upd,
  input  logic              sn_clr,
  input  logic [DATA_W-1:0] sn_data,
  // local actions (index equals lk_idx)
  input  logic              lc_fill,
  input  logic              lc_wr,
  input  logic              lc_set_sole,
  input  logic [TAG_W-1:0]  lc_tag,
  input  logic [DATA_W-1:0] lc_data,
  output logic [LINES-1:0]  valid_o
);
  logic [LINES-1:0]  valid_q, valid_d;
  logic [LINES-1:0]  sole_q, sole_d;
  logic [DATA_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  data_en, data_from_sn, tag_en;
  logic              sn_any;

  assign sn_any = sn_kill | sn_upd | sn_clr;

  assign lk_tag   = tag_q[lk_idx];
  assign lk_data  = data_q[lk_idx];
  assign lk_valid = valid_q[lk_idx];
  assign lk_sole  = sole_q[lk_idx];
  assign sn_tag   = tag_q[sn_idx];
  assign sn_valid = valid_q[sn_idx];
  assign valid_o  = valid_q;

  // next state per line; a snoop action on a line blocks any local action on it
  always_comb begin
    valid_d      = valid_q;
    sole_d       = sole_q;
    data_en      = '0;
    data_from_sn = '0;
    tag_en       = '0;
    for (int l = 0; l < LINES; l++) begin
      if (sn_any && (sn_idx == IDX_W'(l))) begin
        sole_d[l] = 1'b0;
        if (sn_kill) valid_d[l] = 1'b0;
        if (sn_upd) begin
          data_en[l]      = 1'b1;
          data_from_sn[l] = 1'b1;
        end
      end else if (lk_idx == IDX_W'(l)) begin
        if (lc_fill) begin
          valid_d[l] = 1'b1;
          sole_d[l]  = 1'b0;
          tag_en[l]  = 1'b1;
          data_en[l] = 1'b1;
        end else begin
          if (lc_wr) data_en[l] = 1'b1;
          if (lc_set_sole) sole_d[l] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      sole_q  <= '0;
    end else begin
      valid_q <= valid_d;
      sole_q  <= sole_d;
    end
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (data_en[g]) data_q[g] <= data_from_sn[g] ? sn_data : lc_data;
        if (tag_en[g])  tag_q[g]  <= lc_tag;
      end
    end
  endgenerate
endmodule

// File: rtl/swc_snoop.sv
module swc_snoop #(
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3,
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0,
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_kind_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [ID_W-1:0]   bus_src_i,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic              line_valid,
  output logic [IDX_W-1:0]  sn_idx,
  output logic              sn_peer,
  output logic              sn_kill,
  output logic              sn_upd,
  output logic              sn_clr
);
  import swc_pkg::*;
  logic match;

  assign sn_idx  = bus_addr_i[IDX_W-1:0];
  assign sn_peer = bus_valid_i && (bus_src_i != ID_W'(CORE_ID));
  assign match   = sn_peer && line_valid && (line_tag == bus_addr_i[ADDR_W-1:IDX_W]);
  assign sn_kill = match && (bus_kind_i == MSG_INV);
  assign sn_upd  = match && (bus_kind_i == MSG_UPD);
  assign sn_clr  = match && (bus_kind_i == MSG_FILL);
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl #(
  parameter int UPDATE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                hit,
  input  logic                sole,
  input  logic                stall,
  input  logic                mem_ack,
  output logic                req_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic                lc_fill,
  output logic                lc_wr,
  output logic                lc_set_sole,
  output logic                send,
  output swc_pkg::msg_kind_e  kind,
  output logic                from_mem
);
  import swc_pkg::*;
  ctl_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    req_ready   = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    lc_fill     = 1'b0;
    lc_wr       = 1'b0;
    lc_set_sole = 1'b0;
    send        = 1'b0;
    kind        = MSG_NONE;
    from_mem    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && !stall) begin
          if (req_write)  st_d = ST_WRT;
          else if (hit)   req_ready = 1'b1;
          else            st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        from_mem = 1'b1;
        if (mem_ack) begin
          req_ready = 1'b1;
          lc_fill   = 1'b1;
          send      = 1'b1;
          kind      = MSG_FILL;
          st_d      = ST_IDLE;
        end
      end
      ST_WRT: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          req_ready = 1'b1;
          lc_wr     = hit;
          st_d      = ST_IDLE;
          if (UPDATE != 0) begin
            send = 1'b1;
            kind = MSG_UPD;
          end else begin
            send        = !(hit && sole);
            kind        = MSG_INV;
            lc_set_sole = hit;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3,
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0,
  parameter int UPDATE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              bus_valid_o,
  output logic [1:0]        bus_kind_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic [ID_W-1:0]   bus_src_o,
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_kind_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [ID_W-1:0]   bus_src_i
);
  import swc_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0]  req_idx, sn_idx;
  logic [TAG_W-1:0]  req_tag, lk_tag, sn_tag;
  logic [DATA_W-1:0] lk_data, fill_data;
  logic              lk_valid, lk_sole, sn_valid, hit, stall;
  logic              sn_peer, sn_kill, sn_upd, sn_clr;
  logic              lc_fill, lc_wr, lc_set_sole, send, from_mem;
  msg_kind_e         kind;
  logic [LINES-1:0]  valid_vec;

  assign req_idx   = req_addr[IDX_W-1:0];
  assign req_tag   = req_addr[ADDR_W-1:IDX_W];
  assign hit       = lk_valid && (lk_tag == req_tag);
  assign stall     = sn_peer && (sn_idx == req_idx);
  assign fill_data = lc_fill ? mem_rdata : req_wdata;

  swc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_idx), .lk_tag(lk_tag), .lk_data(lk_data),
    .lk_valid(lk_valid), .lk_sole(lk_sole),
    .sn_idx(sn_idx), .sn_tag(sn_tag), .sn_valid(sn_valid),
    .sn_kill(sn_kill), .sn_upd(sn_upd), .sn_clr(sn_clr), .sn_data(bus_data_i),
    .lc_fill(lc_fill), .lc_wr(lc_wr), .lc_set_sole(lc_set_sole),
    .lc_tag(req_tag), .lc_data(fill_data), .valid_o(valid_vec)
  );

  swc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .CORE_ID(CORE_ID)) u_snoop (
    .bus_valid_i(bus_valid_i), .bus_kind_i(bus_kind_i), .bus_addr_i(bus_addr_i),
    .bus_src_i(bus_src_i), .line_tag(sn_tag), .line_valid(sn_valid),
    .sn_idx(sn_idx), .sn_peer(sn_peer), .sn_kill(sn_kill), .sn_upd(sn_upd), .sn_clr(sn_clr)
  );

  swc_ctrl #(.UPDATE(UPDATE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .hit(hit), .sole(lk_sole),
    .stall(stall), .mem_ack(mem_ack),
    .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we),
    .lc_fill(lc_fill), .lc_wr(lc_wr), .lc_set_sole(lc_set_sole),
    .send(send), .kind(kind), .from_mem(from_mem)
  );

  assign req_rdata   = from_mem ? mem_rdata : lk_data;
  assign mem_addr    = req_addr;
  assign mem_wdata   = req_wdata;
  assign bus_valid_o = send;
  assign bus_kind_o  = kind;
  assign bus_addr_o  = req_addr;
  assign bus_data_o  = fill_data;
  assign bus_src_o   = ID_W'(CORE_ID);
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
  parameter int IDX_W   = 3,
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0,
  parameter int UPDATE  = 0,
  localparam int LINES  = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic             bus_valid_o,
  input logic [1:0]       bus_kind_o,
  input logic [ID_W-1:0]  bus_src_o,
  input logic             lc_fill,
  input logic             sn_kill,
  input logic [IDX_W-1:0] sn_idx,
  input logic [IDX_W-1:0] req_idx,
  input logic [LINES-1:0] valid_vec
);
  a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  a_r4_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_ready) |-> (mem_req && mem_we && mem_ack));

  a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_fill && !sn_kill) |=> valid_vec[$past(req_idx)]);

  a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sn_kill |=> !valid_vec[$past(sn_idx)]);

  a_r5_own_src: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> (bus_src_o == ID_W'(CORE_ID)));

  a_r9_update_each_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((UPDATE != 0) && req_valid && req_write && req_ready) |-> (bus_valid_o && bus_kind_o == 2'd2));
endmodule

bind snoop_wt_cache swc_chk #(.IDX_W(IDX_W), .ID_W(ID_W), .CORE_ID(CORE_ID), .UPDATE(UPDATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .bus_valid_o(bus_valid_o), .bus_kind_o(bus_kind_o), .bus_src_o(bus_src_o),
  .lc_fill(lc_fill), .sn_kill(sn_kill), .sn_idx(sn_idx), .req_idx(req_idx), .valid_vec(valid_vec)
);

// File: tb/sim_snoop_wt_cache.sv
`timescale 1ns/1ps
module sim_snoop_wt_cache;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rv [4], rw [4], rr [4];
  logic [AW-1:0] ra [4];
  logic [DW-1:0] rwd [4], rrd [4];
  logic          mq [4], mwe [4];
  logic [AW-1:0] ma [4];
  logic [DW-1:0] mwd [4];
  logic          bv [4];
  logic [1:0]    bk [4];
  logic [AW-1:0] bad [4];
  logic [DW-1:0] bd [4];
  logic [IW-1:0] bs [4];

  logic          gq [2], gwe [2], gack [2], gbv [2];
  logic [AW-1:0] gma [2], gba [2];
  logic [DW-1:0] gwd [2], grd [2], gbd [2];
  logic [1:0]    gbk [2];
  logic [IW-1:0] gbs [2];
  logic [DW-1:0] mem [2][256];

  int msg_cnt [2];
  logic [1:0]    last_k [2];
  logic [AW-1:0] last_a [2];
  logic [DW-1:0] last_d [2];
  logic [IW-1:0] last_s [2];

  int n_chk = 0;
  int n_fail = 0;

  generate
    for (genvar k = 0; k < 4; k++) begin : g_c
      snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3), .ID_W(IW),
                       .CORE_ID(k % 2), .UPDATE(k / 2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rv[k]), .req_write(rw[k]), .req_addr(ra[k]), .req_wdata(rwd[k]),
        .req_ready(rr[k]), .req_rdata(rrd[k]),
        .mem_req(mq[k]), .mem_we(mwe[k]), .mem_addr(ma[k]), .mem_wdata(mwd[k]),
        .mem_ack(gack[k/2]), .mem_rdata(grd[k/2]),
        .bus_valid_o(bv[k]), .bus_kind_o(bk[k]), .bus_addr_o(bad[k]),
        .bus_data_o(bd[k]), .bus_src_o(bs[k]),
        .bus_valid_i(gbv[k/2]), .bus_kind_i(gbk[k/2]), .bus_addr_i(gba[k/2]),
        .bus_data_i(gbd[k/2]), .bus_src_i(gbs[k/2])
      );
    end
  endgenerate

  // per-group shared memory and bus; one active core per group at a time
  always_comb begin
    for (int g = 0; g < 2; g++) begin
      gq[g]  = mq[2*g] | mq[2*g+1];
      gwe[g] = mq[2*g] ? mwe[2*g] : mwe[2*g+1];
      gma[g] = mq[2*g] ? ma[2*g]  : ma[2*g+1];
      gwd[g] = mq[2*g] ? mwd[2*g] : mwd[2*g+1];
      grd[g] = mem[g][gma[g]];
      gbv[g] = bv[2*g] | bv[2*g+1];
      gbk[g] = bv[2*g] ? bk[2*g]  : bk[2*g+1];
      gba[g] = bv[2*g] ? bad[2*g] : bad[2*g+1];
      gbd[g] = bv[2*g] ? bd[2*g]  : bd[2*g+1];
      gbs[g] = bv[2*g] ? bs[2*g]  : bs[2*g+1];
    end
  end

  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      if (!rst_n) begin
        gack[g]    <= 1'b0;
        msg_cnt[g] <= 0;
        for (int a = 0; a < 256; a++) mem[g][a] <= DW'(16'h1000 + a);
      end else begin
        gack[g] <= gq[g] && !gack[g];
        if (gack[g] && gwe[g]) mem[g][gma[g]] <= gwd[g];
        if (gbv[g]) begin
          msg_cnt[g] <= msg_cnt[g] + 1;
          last_k[g]  <= gbk[g];
          last_a[g]  <= gba[g];
          last_d[g]  <= gbd[g];
          last_s[g]  <= gbs[g];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic core_op(input int k, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] q, output int lat);
    @(negedge clk);
    rv[k] = 1'b1; rw[k] = we; ra[k] = a; rwd[k] = d;
    lat = 0;
    #1;
    while (!rr[k]) begin
      @(negedge clk);
      #1;
      lat++;
    end
    q = rrd[k];
    @(posedge clk);
    #1 rv[k] = 1'b0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) begin
      rv[k] = 1'b0; rw[k] = 1'b0; ra[k] = '0; rwd[k] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(!mq[k] && !bv[k] && !rr[k], "R1", "idle outputs after reset",
            {mq[k], bv[k], rr[k]}, 0);
    end
  endtask

  task automatic t_miss_hit;
    logic [DW-1:0] q; int lat;
    core_op(0, 1'b0, 8'd5, '0, q, lat);
    check(lat == 2, "R2", "miss latency", lat, 2);
    check(q == 16'h1005, "R2", "miss data", q, 16'h1005);
    check(last_k[0] == 2'd3 && last_a[0] == 8'd5, "R2", "refill message kind", last_k[0], 3);
    core_op(0, 1'b0, 8'd5, '0, q, lat);
    check(lat == 0, "R3", "hit latency", lat, 0);
    check(q == 16'h1005, "R3", "hit data", q, 16'h1005);
  endtask

  task automatic t_invalidate;
    logic [DW-1:0] q; int lat, c0;
    core_op(1, 1'b0, 8'd5, '0, q, lat);
    check(lat == 2, "R2", "peer miss latency", lat, 2);
    c0 = msg_cnt[0];
    core_op(0, 1'b1, 8'd5, 16'hAAAA, q, lat);
    check(lat == 2, "R4", "write latency", lat, 2);
    check(mem[0][5] == 16'hAAAA, "R4", "memory after write", mem[0][5], 16'hAAAA);
    check(msg_cnt[0] == c0 + 1, "R5", "one message per write", msg_cnt[0] - c0, 1);
    check(last_k[0] == 2'd1 && last_a[0] == 8'd5 && last_s[0] == 2'd0, "R5",
          "invalidate kind/addr/src", {last_k[0], last_a[0], last_s[0]}, {2'd1, 8'd5, 2'd0});
    core_op(0, 1'b0, 8'd5, '0, q, lat);
    check(lat == 0 && q == 16'hAAAA, "R10", "writer keeps own line", {lat[3:0], q}, {4'd0, 16'hAAAA});
    core_op(1, 1'b0, 8'd5, '0, q, lat);
    check(lat == 2, "R6", "invalidated peer misses", lat, 2);
    check(q == 16'hAAAA, "R6", "no stale value", q, 16'hAAAA);
  endtask

  task automatic t_sole;
    logic [DW-1:0] q; int lat, c0;
    core_op(0, 1'b0, 8'd9, '0, q, lat);
    c0 = msg_cnt[0];
    core_op(0, 1'b1, 8'd9, 16'd1, q, lat);
    check(msg_cnt[0] == c0 + 1, "R5", "first write invalidates", msg_cnt[0] - c0, 1);
    core_op(0, 1'b1, 8'd9, 16'd2, q, lat);
    core_op(0, 1'b1, 8'd9, 16'd3, q, lat);
    check(msg_cnt[0] == c0 + 1, "R7", "repeat writes silent", msg_cnt[0] - c0, 1);
    check(mem[0][9] == 16'd3, "R7", "repeat writes reach memory", mem[0][9], 3);
    core_op(0, 1'b0, 8'd9, '0, q, lat);
    check(lat == 0 && q == 16'd3, "R7", "line keeps last write", {lat[3:0], q}, {4'd0, 16'd3});
  endtask

  task automatic t_sole_clear;
    logic [DW-1:0] q; int lat, c0;
    core_op(1, 1'b0, 8'd9, '0, q, lat);
    check(q == 16'd3, "R8", "peer refill data", q, 3);
    c0 = msg_cnt[0];
    core_op(0, 1'b1, 8'd9, 16'd4, q, lat);
    check(msg_cnt[0] == c0 + 1 && last_k[0] == 2'd1, "R8", "invalidate after peer refill",
          msg_cnt[0] - c0, 1);
    core_op(1, 1'b0, 8'd9, '0, q, lat);
    check(lat == 2 && q == 16'd4, "R6", "peer refetches new value", {lat[3:0], q}, {4'd2, 16'd4});
  endtask

  task automatic t_write_miss;
    logic [DW-1:0] q; int lat;
    core_op(0, 1'b1, 8'd20, 16'h0055, q, lat);
    check(mem[0][20] == 16'h0055, "R4", "write miss reaches memory", mem[0][20], 16'h0055);
    core_op(0, 1'b0, 8'd20, '0, q, lat);
    check(lat == 2, "R4", "write miss does not allocate", lat, 2);
    check(q == 16'h0055, "R4", "read after write miss", q, 16'h0055);
  endtask

  task automatic t_update;
    logic [DW-1:0] q; int lat, c0;
    core_op(2, 1'b0, 8'd5, '0, q, lat);
    core_op(3, 1'b0, 8'd5, '0, q, lat);
    check(q == 16'h1005, "R2", "update group fill", q, 16'h1005);
    c0 = msg_cnt[1];
    core_op(2, 1'b1, 8'd5, 16'h1234, q, lat);
    check(msg_cnt[1] == c0 + 1 && last_k[1] == 2'd2 && last_d[1] == 16'h1234, "R9",
          "update message 1", last_d[1], 16'h1234);
    core_op(2, 1'b1, 8'd5, 16'h4321, q, lat);
    check(msg_cnt[1] == c0 + 2 && last_k[1] == 2'd2 && last_d[1] == 16'h4321, "R9",
          "update message 2", msg_cnt[1] - c0, 2);
    core_op(3, 1'b0, 8'd5, '0, q, lat);
    check(lat == 0 && q == 16'h4321, "R9", "peer updated in place", {lat[3:0], q}, {4'd0, 16'h4321});
    core_op(2, 1'b0, 8'd5, '0, q, lat);
    check(lat == 0 && q == 16'h4321, "R10", "writer ignores own update", {lat[3:0], q}, {4'd0, 16'h4321});
    check(mem[1][5] == 16'h4321, "R4", "update memory", mem[1][5], 16'h4321);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_miss_hit();
    t_invalidate();
    t_sole();
    t_sole_clear();
    t_write_miss();
    t_update();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule